// File: doc/BRIEF.md
# Dual-Priority Transmit Queue Controller

This block holds transmit descriptors for a small set of channels. Each channel owns two descriptor FIFOs, one urgent and one bulk. Enqueue requests carry a channel number, a priority bit and a descriptor. A scheduler asks for one descriptor at a time from a named channel, and a per-channel arbiter decides which of the two FIFOs answers. The arbiter runs either in strict priority or in a ratio mode that grants N urgent services for each bulk service, with N set by configuration.

Each FIFO has two configurable levels. The lower one is a watermark and the upper one is a high threshold. Both are reported on a flat status vector so that an upstream source can throttle without touching the data path. Discard at the high threshold can be enabled separately for each priority. A rejected descriptor leaves the FIFO untouched and raises a one-cycle drop strobe that names the channel and the priority.

Top module: `tq_dual_prio`

## Requirements
- R1: After reset, every FIFO is empty, `deq_valid_o` and `drop_o` are 0, and every `qstat_o` bit whose level is non-zero reads 0.
- R2: Each FIFO returns descriptors in arrival order. A dequeue request presented before a clock edge shows its result on `deq_valid_o`, `deq_hi_o` and `deq_desc_o` after that edge.
- R3: Status for channel c sits at `qstat_o[4c+3:4c]` as {hi_thr, hi_wm, lo_thr, lo_wm}. A watermark bit is 1 while the fill is at or above its watermark and 0 while the fill is below it. It reflects the fill after the same edge that changed the fill.
- R4: A threshold bit in `qstat_o` is 1 while the fill is at or above the high threshold of that FIFO, and it clears in the cycle after the dequeue that takes the fill below it.
- R5: `cfg_discard_i` holds one enable per priority: bit 1 for urgent, bit 0 for bulk. When the enable is set and the fill is at or above the high threshold, an enqueue to that FIFO is dropped. `drop_o` is then 1 for one cycle after the edge, with `drop_ch_o` and `drop_hi_o` naming the target, and the stored contents and fill stay the same.
- R6: An enqueue to a full FIFO is always dropped and strobed as in R5, whatever `cfg_discard_i` holds.
- R7: With discard disabled, enqueues above the high threshold are accepted until the FIFO is full.
- R8: With `cfg_weighted_i`=0, a non-empty urgent FIFO is always served before the bulk FIFO of the same channel.
- R9: With `cfg_weighted_i`=1 and weight N, each channel counts its urgent services since its last bulk service. When both FIFOs are non-empty, bulk is served once that count reaches N. A FIFO that is alone in holding data is always served, and N=0 puts bulk first.
- R10: A dequeue request to a channel whose two FIFOs are both empty gives `deq_valid_o`=0 and changes no state.
- R11: Channels are independent: traffic on one channel changes neither the status bits nor the dequeue results of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_hi_wm_i | input | CNT_W | Urgent FIFO watermark |
| cfg_hi_thr_i | input | CNT_W | Urgent FIFO high threshold |
| cfg_lo_wm_i | input | CNT_W | Bulk FIFO watermark |
| cfg_lo_thr_i | input | CNT_W | Bulk FIFO high threshold |
| cfg_discard_i | input | 2 | Discard enable: bit 1 urgent, bit 0 bulk |
| cfg_weighted_i | input | 1 | 0 strict, 1 ratio arbitration |
| cfg_weight_i | input | WGT_W | Urgent services per bulk service |
| enq_valid_i | input | 1 | Enqueue request |
| enq_ch_i | input | CH_W | Enqueue channel |
| enq_hi_i | input | 1 | Enqueue priority (1 urgent) |
| enq_desc_i | input | DESC_W | Descriptor to store |
| deq_req_i | input | 1 | Dequeue request |
| deq_ch_i | input | CH_W | Dequeue channel |
| deq_valid_o | output | 1 | Descriptor returned |
| deq_hi_o | output | 1 | Priority of returned descriptor |
| deq_desc_o | output | DESC_W | Returned descriptor |
| drop_o | output | 1 | One-cycle drop strobe |
| drop_ch_o | output | CH_W | Channel of dropped enqueue |
| drop_hi_o | output | 1 | Priority of dropped enqueue |
| qstat_o | output | 4*NUM_CH | Per-channel level flags |

## Verification
A wrong fill count shows in `qstat_o` on the first edge after the enqueue or dequeue that disturbs it. It also shows at a drop strobe that comes too early or too late, or at a descriptor returned out of order. A broken read or write pointer gives a wrong `deq_desc_o` on the next dequeue of that FIFO. A ratio counter that is off by one shows up in the grant sequence within N+1 dequeues of a channel that holds both kinds of traffic. The directed sequences therefore read status after every change of level and compare the full grant order.

// File: rtl/tq_pkg.sv
package tq_pkg;
  localparam int STAT_PER_CH = 4;
  localparam int PRIO_LO = 0;
  localparam int PRIO_HI = 1;
endpackage

// File: rtl/tq_fifo.sv
module tq_fifo #(
  parameter int DESC_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DESC_W-1:0] data_i,
  output logic [DESC_W-1:0] head_o,
  output logic [CNT_W-1:0]  fill_o
);
  logic [DESC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_o <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      if (push_i && !pop_i)      fill_o <= fill_o + CNT_W'(1);
      else if (pop_i && !push_i) fill_o <= fill_o - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  assign head_o = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (fill_o < CNT_W'(DEPTH))); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (fill_o != '0)); // R10
endmodule

// File: rtl/tq_arb.sv
module tq_arb #(
  parameter int WGT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_ne_i,
  input  logic             lo_ne_i,
  input  logic             weighted_i,
  input  logic [WGT_W-1:0] weight_i,
  input  logic             grant_i,
  output logic             pick_hi_o
);
  logic [WGT_W-1:0] run_q;

  assign pick_hi_o = hi_ne_i && (!lo_ne_i || !weighted_i || (run_q < weight_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (grant_i) begin
      if (!pick_hi_o)            run_q <= '0;
      else if (run_q < weight_i) run_q <= run_q + WGT_W'(1);
    end
  end
endmodule

// File: rtl/tq_dual_prio.sv
module tq_dual_prio
  import tq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DESC_W = 16,
  parameter int DEPTH  = 8,
  parameter int WGT_W  = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [CNT_W-1:0]            cfg_hi_wm_i,
  input  logic [CNT_W-1:0]            cfg_hi_thr_i,
  input  logic [CNT_W-1:0]            cfg_lo_wm_i,
  input  logic [CNT_W-1:0]            cfg_lo_thr_i,
  input  logic [1:0]                  cfg_discard_i,
  input  logic                        cfg_weighted_i,
  input  logic [WGT_W-1:0]            cfg_weight_i,
  input  logic                        enq_valid_i,
  input  logic [CH_W-1:0]             enq_ch_i,
  input  logic                        enq_hi_i,
  input  logic [DESC_W-1:0]           enq_desc_i,
  input  logic                        deq_req_i,
  input  logic [CH_W-1:0]             deq_ch_i,
  output logic                        deq_valid_o,
  output logic                        deq_hi_o,
  output logic [DESC_W-1:0]           deq_desc_o,
  output logic                        drop_o,
  output logic [CH_W-1:0]             drop_ch_o,
  output logic                        drop_hi_o,
  output logic [STAT_PER_CH*NUM_CH-1:0] qstat_o
);
  logic [CNT_W-1:0]  wm  [2];
  logic [CNT_W-1:0]  thr [2];
  logic [CNT_W-1:0]  fill [NUM_CH][2];
  logic [DESC_W-1:0] head [NUM_CH][2];
  logic [1:0]        push [NUM_CH];
  logic [1:0]        pop  [NUM_CH];
  logic [1:0]        rej  [NUM_CH];
  logic [NUM_CH-1:0] pick_hi, any_ne;

  assign wm[PRIO_LO]  = cfg_lo_wm_i;
  assign wm[PRIO_HI]  = cfg_hi_wm_i;
  assign thr[PRIO_LO] = cfg_lo_thr_i;
  assign thr[PRIO_HI] = cfg_hi_thr_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic deq_sel;
    assign deq_sel   = deq_req_i && (deq_ch_i == CH_W'(c));
    assign any_ne[c] = (fill[c][PRIO_HI] != '0) || (fill[c][PRIO_LO] != '0);

    for (genvar p = 0; p < 2; p++) begin : g_pr
      logic enq_sel;
      assign enq_sel  = enq_valid_i && (enq_ch_i == CH_W'(c)) && (enq_hi_i == 1'(p));
      assign rej[c][p] = (fill[c][p] == CNT_W'(DEPTH)) ||
                         (cfg_discard_i[p] && (fill[c][p] >= thr[p]));
      assign push[c][p] = enq_sel && !rej[c][p];

      tq_fifo #(.DESC_W(DESC_W), .DEPTH(DEPTH)) u_fifo (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (push[c][p]),
        .pop_i  (pop[c][p]),
        .data_i (enq_desc_i),
        .head_o (head[c][p]),
        .fill_o (fill[c][p])
      );

      assign qstat_o[STAT_PER_CH*c + 2*p]     = fill[c][p] >= wm[p];
      assign qstat_o[STAT_PER_CH*c + 2*p + 1] = fill[c][p] >= thr[p];

      AST_DROP_KEEPS_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enq_sel && rej[c][p] && !pop[c][p]) |=> (fill[c][p] == $past(fill[c][p]))); // R5
    end

    tq_arb #(.WGT_W(WGT_W)) u_arb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hi_ne_i    (fill[c][PRIO_HI] != '0),
      .lo_ne_i    (fill[c][PRIO_LO] != '0),
      .weighted_i (cfg_weighted_i),
      .weight_i   (cfg_weight_i),
      .grant_i    (deq_sel && any_ne[c]),
      .pick_hi_o  (pick_hi[c])
    );

    assign pop[c][PRIO_HI] = deq_sel && pick_hi[c];
    assign pop[c][PRIO_LO] = deq_sel && (fill[c][PRIO_LO] != '0) && !pick_hi[c];

    AST_STRICT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deq_sel && !cfg_weighted_i && fill[c][PRIO_HI] != '0) |=> (deq_valid_o && deq_hi_o)); // R8
    AST_EMPTY_DEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deq_sel && !any_ne[c]) |=> !deq_valid_o); // R10
  end

  logic              deq_v_d, deq_hi_d, drop_d;
  logic [DESC_W-1:0] deq_desc_d;

  always_comb begin
    deq_v_d    = 1'b0;
    deq_hi_d   = 1'b0;
    deq_desc_d = '0;
    drop_d     = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (deq_req_i && deq_ch_i == CH_W'(c) && any_ne[c]) begin
        deq_v_d    = 1'b1;
        deq_hi_d   = pick_hi[c];
        deq_desc_d = pick_hi[c] ? head[c][PRIO_HI] : head[c][PRIO_LO];
      end
      if (enq_valid_i && enq_ch_i == CH_W'(c))
        drop_d = rej[c][enq_hi_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deq_valid_o <= 1'b0;
      deq_hi_o    <= 1'b0;
      deq_desc_o  <= '0;
      drop_o      <= 1'b0;
      drop_ch_o   <= '0;
      drop_hi_o   <= 1'b0;
    end else begin
      deq_valid_o <= deq_v_d;
      deq_hi_o    <= deq_hi_d;
      if (deq_v_d) deq_desc_o <= deq_desc_d;
      drop_o      <= drop_d;
      if (drop_d) begin
        drop_ch_o <= enq_ch_i;
        drop_hi_o <= enq_hi_i;
      end
    end
  end

  AST_DROP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $past(enq_valid_i)); // R5
endmodule

// File: tb/tq_dual_prio_test.sv
module tq_dual_prio_test;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 2;
  localparam int DESC_W = 16;
  localparam int DEPTH  = 8;
  localparam int WGT_W  = 4;
  localparam int CH_W   = 1;
  localparam int CNT_W  = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [CNT_W-1:0] hi_wm = 4'd3, hi_thr = 4'd6, lo_wm = 4'd2, lo_thr = 4'd5;
  logic [1:0] discard = 2'b00;
  logic weighted = 1'b0;
  logic [WGT_W-1:0] weight = 4'd2;
  logic enq_v = 1'b0, enq_hi = 1'b0, deq_r = 1'b0;
  logic [CH_W-1:0] enq_ch = '0, deq_ch = '0;
  logic [DESC_W-1:0] enq_d = '0;
  logic deq_v, deq_hi, drop, drop_hi;
  logic [DESC_W-1:0] deq_d;
  logic [CH_W-1:0] drop_ch;
  logic [4*NUM_CH-1:0] qstat;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tq_dual_prio #(.NUM_CH(NUM_CH), .DESC_W(DESC_W), .DEPTH(DEPTH), .WGT_W(WGT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_hi_wm_i(hi_wm), .cfg_hi_thr_i(hi_thr), .cfg_lo_wm_i(lo_wm), .cfg_lo_thr_i(lo_thr),
    .cfg_discard_i(discard), .cfg_weighted_i(weighted), .cfg_weight_i(weight),
    .enq_valid_i(enq_v), .enq_ch_i(enq_ch), .enq_hi_i(enq_hi), .enq_desc_i(enq_d),
    .deq_req_i(deq_r), .deq_ch_i(deq_ch),
    .deq_valid_o(deq_v), .deq_hi_o(deq_hi), .deq_desc_o(deq_d),
    .drop_o(drop), .drop_ch_o(drop_ch), .drop_hi_o(drop_hi), .qstat_o(qstat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic enq(input int ch, input bit hi, input logic [DESC_W-1:0] d);
    enq_v = 1'b1; enq_ch = CH_W'(ch); enq_hi = hi; enq_d = d;
    @(negedge clk);
    enq_v = 1'b0;
  endtask

  task automatic deq_expect(input string tag, input int ch, input bit v, input bit hi,
                            input logic [DESC_W-1:0] d);
    deq_r = 1'b1; deq_ch = CH_W'(ch);
    @(negedge clk);
    deq_r = 1'b0;
    chk(tag, {31'd0, deq_v}, {31'd0, v});
    if (v) begin
      chk(tag, {31'd0, deq_hi}, {31'd0, hi});
      chk(tag, {16'd0, deq_d}, {16'd0, d});
    end
  endtask

  function automatic logic [3:0] st(input int ch);
    return qstat[4*ch +: 4];
  endfunction

  task automatic t_reset;
    chk("R1 deq_valid", {31'd0, deq_v}, 0);
    chk("R1 drop", {31'd0, drop}, 0);
    chk("R1 qstat", {28'd0, qstat}, 0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 3; i++) enq(0, 0, 16'hA000 + 16'(i));
    for (int i = 0; i < 3; i++) deq_expect("R2 order", 0, 1, 0, 16'hA000 + 16'(i));
    deq_expect("R10 empty deq", 0, 0, 0, 0);
    chk("R10 state after empty deq", {28'd0, st(0)}, 0);
  endtask

  task automatic t_wm;
    enq(0, 1, 16'hB000); enq(0, 1, 16'hB001);
    chk("R3 below wm", {28'd0, st(0)}, 4'b0000);
    enq(0, 1, 16'hB002);
    chk("R3 at wm", {28'd0, st(0)}, 4'b0100);
    for (int i = 3; i < 6; i++) enq(0, 1, 16'hB000 + 16'(i));
    chk("R4 at thr", {28'd0, st(0)}, 4'b1100);
    chk("R11 other ch", {28'd0, st(1)}, 4'b0000);
    deq_expect("R2 hi deq", 0, 1, 1, 16'hB000);
    chk("R4 below thr", {28'd0, st(0)}, 4'b0100);
    deq_expect("R2 hi deq", 0, 1, 1, 16'hB001);
    deq_expect("R2 hi deq", 0, 1, 1, 16'hB002);
    chk("R3 still at wm", {28'd0, st(0)}, 4'b0100);
    deq_expect("R2 hi deq", 0, 1, 1, 16'hB003);
    chk("R3 below wm clears", {28'd0, st(0)}, 4'b0000);
    deq_expect("R2 hi deq", 0, 1, 1, 16'hB004);
    deq_expect("R2 hi deq", 0, 1, 1, 16'hB005);
  endtask

  task automatic t_discard;
    discard = 2'b01;
    for (int i = 0; i < 5; i++) enq(1, 0, 16'hC000 + 16'(i));
    chk("R5 accepted below thr", {31'd0, drop}, 0);
    chk("R5 stat", {28'd0, st(1)}, 4'b0011);
    enq(1, 0, 16'hC005);
    chk("R5 drop strobe", {31'd0, drop}, 1);
    chk("R5 drop ch", {31'd0, drop_ch}, 1);
    chk("R5 drop prio", {31'd0, drop_hi}, 0);
    @(negedge clk);
    chk("R5 strobe one cycle", {31'd0, drop}, 0);
    chk("R5 stat unchanged", {28'd0, st(1)}, 4'b0011);
    for (int i = 0; i < 5; i++) deq_expect("R5 contents", 1, 1, 0, 16'hC000 + 16'(i));
    deq_expect("R5 dropped absent", 1, 0, 0, 0);
    discard = 2'b00;
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) begin
      enq(1, 1, 16'hD000 + 16'(i));
      chk("R7 no drop above thr", {31'd0, drop}, 0);
    end
    chk("R7 stat", {28'd0, st(1)}, 4'b1100);
    enq(1, 1, 16'hD008);
    chk("R6 full drop", {31'd0, drop}, 1);
    chk("R6 drop prio", {31'd0, drop_hi}, 1);
    for (int i = 0; i < 8; i++) deq_expect("R6 contents", 1, 1, 1, 16'hD000 + 16'(i));
    deq_expect("R6 nothing extra", 1, 0, 0, 0);
  endtask

  task automatic t_strict;
    enq(0, 0, 16'hE100); enq(0, 1, 16'hE000); enq(0, 0, 16'hE101); enq(0, 1, 16'hE001);
    deq_expect("R8 strict", 0, 1, 1, 16'hE000);
    deq_expect("R8 strict", 0, 1, 1, 16'hE001);
    deq_expect("R8 strict", 0, 1, 0, 16'hE100);
    deq_expect("R8 strict", 0, 1, 0, 16'hE101);
  endtask

  task automatic t_weighted;
    weighted = 1'b1; weight = 4'd2;
    for (int i = 0; i < 4; i++) enq(0, 1, 16'hF000 + 16'(i));
    for (int i = 0; i < 3; i++) enq(0, 0, 16'hF100 + 16'(i));
    deq_expect("R11 idle ch", 1, 0, 0, 0);
    deq_expect("R9 ratio", 0, 1, 1, 16'hF000);
    deq_expect("R9 ratio", 0, 1, 1, 16'hF001);
    deq_expect("R9 ratio", 0, 1, 0, 16'hF100);
    deq_expect("R9 ratio", 0, 1, 1, 16'hF002);
    deq_expect("R9 ratio", 0, 1, 1, 16'hF003);
    deq_expect("R9 ratio", 0, 1, 0, 16'hF101);
    deq_expect("R9 lo alone", 0, 1, 0, 16'hF102);
    weight = 4'd0;
    enq(0, 1, 16'hF200); enq(0, 0, 16'hF300);
    deq_expect("R9 weight zero", 0, 1, 0, 16'hF300);
    deq_expect("R9 weight zero", 0, 1, 1, 16'hF200);
    weighted = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_wm();
    t_discard();
    t_full();
    t_strict();
    t_weighted();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule